// File: doc/BRIEF.md
# Three-Wire Trim DAC Serial Loader

This block writes a new setting into one of eight 8-bit trim DAC channels over a three-wire link. The link has a serial data line, a serial clock line and a load strobe. A caller presents a channel number and an 8-bit setting with a one-cycle request. The block then shifts out an 11-bit word holding the 3-bit channel above the 8-bit setting, starting with the most significant bit. After the last bit it raises the load strobe while clock and data stay low. It then returns all three lines to low.

Every change of the three output lines is followed by a programmable pause, counted in clock cycles. This lets a slow converter be driven from a fast core clock. The pause length is captured when a request is accepted. The request port is wider than the channel field. A channel number outside the implemented range is refused with a one-cycle error pulse and puts nothing on the link. A busy flag covers the whole transfer, and a one-cycle completion pulse marks its end.

Top module: `trim_dac_loader`

## Requirements
- R1: An accepted request sends the 11-bit word {channel[2:0], setting[7:0]} most significant bit first. Each bit produces exactly one low-to-high transition on `ser_clk`, 11 in total, and the receiver samples `ser_dat` at that transition.
- R2: For each bit, `ser_dat` takes its new value while `ser_clk` is low, and it does not change while `ser_clk` is high.
- R3: Each line state is held for D cycles before the next change, where D = `pause_cycles`, or D = 1 when `pause_cycles` is 0. So `ser_clk` is high for 11·D cycles in total, and the full transfer takes 24·D cycles.
- R4: After the clock-high state of the final bit, `ser_load` is high for D cycles with `ser_clk` and `ser_dat` low. The link then stays all-low for D more cycles before the transfer ends.
- R5: A request whose channel number is 8 or more (`NUM_CH` = 8) gives `cfg_err` high for exactly one cycle, one cycle after the request. It does not raise `busy` and causes no activity on the three link lines.
- R6: `busy` is high from the cycle after acceptance until the transfer ends. Requests seen while `busy` is high are ignored and do not change the word in flight. While `busy` is low, all three link lines are low.
- R7: `done` is a one-cycle pulse. It is raised in the cycle in which `busy` falls, once the final all-low pause has elapsed.
- R8: `pause_cycles` is captured at acceptance. Changing it during a transfer does not change that transfer's timing.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle load request, taken only while idle |
| req_chan | input | REQ_CH_W (4) | Target channel number |
| req_value | input | VAL_W (8) | Setting to load |
| pause_cycles | input | PAUSE_W (8) | Cycles each line state is held (0 is treated as 1) |
| ser_dat | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| ser_load | output | 1 | Load strobe that latches the shifted word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | One-cycle pulse when a channel number is out of range |

## Verification
The hardest situation to create from the ports is a request that arrives in the middle of a transfer while the pause setting also changes. The question is whether either one leaks into the word being shifted or into its timing. For every accepted request, the bench changes `pause_cycles` in the cycle after acceptance. A few cycles into the transfer it also pulses `req_valid` with a different channel and setting. It then rebuilds the received word from `ser_dat` at each clock rise and compares that word, and every phase length, against values computed from the original request. Channel and setting are swept over every combination at the shortest pauses. Longer pauses use a subset, and every out-of-range channel number is tried.

// File: rtl/trim_dac_pkg.sv
package trim_dac_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_DATA = 3'd1,
      PH_CLK  = 3'd2,
      PH_LOAD = 3'd3,
      PH_REST = 3'd4
   } link_phase_e;

endpackage

// File: rtl/trim_tick_timer.sv
module trim_tick_timer #(
   parameter int PAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               rearm,
   input  logic [PAUSE_W-1:0] pause_in,
   output logic               expire
);

   logic [PAUSE_W-1:0] period_q;
   logic [PAUSE_W-1:0] count_q;
   logic [PAUSE_W-1:0] period_d;

   // A zero pause is widened to one cycle per state.
   assign period_d = (pause_in == '0) ? '0 : pause_in - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         count_q  <= '0;
      end else if (arm) begin
         period_q <= period_d;
         count_q  <= period_d;
      end else if (rearm) begin
         count_q  <= period_q;
      end else if (count_q != '0) begin
         count_q  <= count_q - 1'b1;
      end
   end

   assign expire = (count_q == '0);

endmodule

// File: rtl/trim_frame_seq.sv
module trim_frame_seq
   import trim_dac_pkg::*;
#(
   parameter int FRAME_W = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               tick_expire,
   output logic               advance,
   output logic               ser_dat,
   output logic               ser_clk,
   output logic               ser_load,
   output logic               busy,
   output logic               done
);

   localparam int IDX_W = $clog2(FRAME_W);

   link_phase_e        phase_q;
   logic [FRAME_W-1:0] shift_q;
   logic [IDX_W-1:0]   idx_q;

   assign busy    = (phase_q != PH_IDLE);
   assign advance = busy && tick_expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         shift_q  <= '0;
         idx_q    <= '0;
         ser_dat  <= 1'b0;
         ser_clk  <= 1'b0;
         ser_load <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start) begin
               shift_q  <= frame_in;
               ser_dat  <= frame_in[FRAME_W-1];
               ser_clk  <= 1'b0;
               ser_load <= 1'b0;
               idx_q    <= IDX_W'(FRAME_W - 1);
               phase_q  <= PH_DATA;
            end
         end else if (tick_expire) begin
            unique case (phase_q)
               PH_DATA: begin
                  ser_clk <= 1'b1;
                  phase_q <= PH_CLK;
               end
               PH_CLK: begin
                  ser_clk <= 1'b0;
                  if (idx_q == '0) begin
                     ser_dat  <= 1'b0;
                     ser_load <= 1'b1;
                     phase_q  <= PH_LOAD;
                  end else begin
                     shift_q <= shift_q << 1;
                     ser_dat <= shift_q[FRAME_W-2];
                     idx_q   <= idx_q - 1'b1;
                     phase_q <= PH_DATA;
                  end
               end
               PH_LOAD: begin
                  ser_load <= 1'b0;
                  phase_q  <= PH_REST;
               end
               PH_REST: begin
                  done    <= 1'b1;
                  phase_q <= PH_IDLE;
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/trim_dac_loader.sv
module trim_dac_loader #(
   parameter int VAL_W    = 8,
   parameter int CH_W     = 3,
   parameter int REQ_CH_W = 4,
   parameter int NUM_CH   = 8,
   parameter int PAUSE_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [REQ_CH_W-1:0] req_chan,
   input  logic [VAL_W-1:0]    req_value,
   input  logic [PAUSE_W-1:0]  pause_cycles,
   output logic                ser_dat,
   output logic                ser_clk,
   output logic                ser_load,
   output logic                busy,
   output logic                done,
   output logic                cfg_err
);

   localparam int FRAME_W = CH_W + VAL_W;

   if (NUM_CH > (1 << CH_W)) begin : g_bad_nch
      $error("NUM_CH does not fit in the channel field");
   end
   if (REQ_CH_W < CH_W) begin : g_bad_req
      $error("request channel port narrower than channel field");
   end
   if (PAUSE_W < 1) begin : g_bad_pause
      $error("PAUSE_W must be at least 1");
   end

   logic chan_bad;
   logic start;
   logic tick_expire;
   logic advance;
   logic err_q;

   if (NUM_CH >= (1 << REQ_CH_W)) begin : g_no_range
      assign chan_bad = 1'b0;
   end else begin : g_range
      assign chan_bad = ({1'b0, req_chan} >= (REQ_CH_W + 1)'(NUM_CH));
   end

   assign start = req_valid && !busy && !chan_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= req_valid && !busy && chan_bad;
   end
   assign cfg_err = err_q;

   trim_tick_timer #(.PAUSE_W(PAUSE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (start),
      .rearm    (advance),
      .pause_in (pause_cycles),
      .expire   (tick_expire)
   );

   trim_frame_seq #(.FRAME_W(FRAME_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .frame_in    ({req_chan[CH_W-1:0], req_value}),
      .tick_expire (tick_expire),
      .advance     (advance),
      .ser_dat     (ser_dat),
      .ser_clk     (ser_clk),
      .ser_load    (ser_load),
      .busy        (busy),
      .done        (done)
   );

endmodule

// File: rtl/trim_dac_loader_chk.sv
module trim_dac_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic ser_dat,
   input logic ser_clk,
   input logic ser_load,
   input logic busy,
   input logic done,
   input logic cfg_err
);

   // R4
   load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_load |-> (!ser_clk && !ser_dat));

   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_dat));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_dat && !ser_load));

   // R7
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R7
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R5
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!busy && !$past(busy)));

   // R5
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, cfg_err}));

endmodule

bind trim_dac_loader trim_dac_loader_chk u_chk (.*);

// File: tb/sim_trim_dac_loader.sv
module sim_trim_dac_loader;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [3:0] req_chan = '0;
   logic [7:0] req_value = '0;
   logic [7:0] pause_cycles = '0;
   logic       ser_dat, ser_clk, ser_load, busy, done, cfg_err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trim_dac_loader u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_value(req_value), .pause_cycles(pause_cycles), .ser_dat(ser_dat),
      .ser_clk(ser_clk), .ser_load(ser_load), .busy(busy), .done(done),
      .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_ok(input int ch, input int val, input int pause);
      int d, word, exp_word, rises, clk_hi, busy_n, load_n, rest_n;
      int rises_at_load, hold_bad, guard, dat_at_rise;
      bit prev_clk;
      d = (pause == 0) ? 1 : pause;
      exp_word = ((ch & 7) << 8) | (val & 8'hff);
      word = 0; rises = 0; clk_hi = 0; busy_n = 0; load_n = 0; rest_n = 0;
      rises_at_load = -1; hold_bad = 0; guard = 0; dat_at_rise = 0;
      prev_clk = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_chan = 4'(ch); req_value = 8'(val);
      pause_cycles = 8'(pause);
      @(negedge clk);
      req_valid = 1'b0;
      pause_cycles = 8'(pause + 5);   // R8: change after acceptance
      while (!done && guard < 4000) begin
         if (busy) busy_n++;
         if (ser_clk && !prev_clk) begin
            word = (word << 1) | int'(ser_dat);
            rises++;
            dat_at_rise = int'(ser_dat);
         end
         if (ser_clk) begin
            clk_hi++;
            if (int'(ser_dat) != dat_at_rise) hold_bad++;
         end
         if (ser_load) begin
            load_n++;
            if (rises_at_load < 0) rises_at_load = rises;
         end
         if (busy && !ser_load && load_n > 0) rest_n++;
         prev_clk = ser_clk;
         // R6: a competing request in the middle of the transfer
         req_valid = (busy_n == 3);
         req_chan  = 4'(~ch & 7);
         req_value = 8'(~val);
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b0;
      check(done == 1'b1, "R7", "done reached", int'(done), 1);
      check(busy == 1'b0, "R7", "busy low with done", int'(busy), 0);
      check(word == exp_word, "R1", "shifted word", word, exp_word);
      check(rises == 11, "R1", "clock rises", rises, 11);
      check(hold_bad == 0, "R2", "data changes while clock high", hold_bad, 0);
      check(clk_hi == 11 * d, "R3", "clock-high cycles", clk_hi, 11 * d);
      check(busy_n == 24 * d, "R8", "transfer length with changed pause",
            busy_n, 24 * d);
      check(rises_at_load == 11, "R4", "rises before load", rises_at_load, 11);
      check(load_n == d, "R4", "load strobe cycles", load_n, d);
      check(rest_n == d, "R4", "all-low tail cycles", rest_n, d);
      @(negedge clk);
      check(done == 1'b0, "R7", "done one cycle", int'(done), 0);
      check(busy == 1'b0, "R6", "ignored request did not start", int'(busy), 0);
      check({ser_clk, ser_dat, ser_load} == 3'b000, "R6", "idle lines",
            int'({ser_clk, ser_dat, ser_load}), 0);
   endtask

   task automatic run_bad(input int ch, input int val);
      int act;
      act = 0;
      @(negedge clk);
      req_valid = 1'b1; req_chan = 4'(ch); req_value = 8'(val);
      pause_cycles = 8'd1;
      @(negedge clk);
      req_valid = 1'b0;
      check(cfg_err == 1'b1, "R5", "error pulse", int'(cfg_err), 1);
      check(busy == 1'b0, "R5", "no busy on bad channel", int'(busy), 0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         act += int'(ser_clk) + int'(ser_dat) + int'(ser_load) + int'(busy)
              + int'(cfg_err);
      end
      check(act == 0, "R5", "no link activity after error", act, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9
      check({ser_dat, ser_clk, ser_load, busy, done, cfg_err} == 6'b0, "R9",
            "outputs in reset", int'({ser_dat, ser_clk, ser_load, busy, done, cfg_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({ser_dat, ser_clk, ser_load, busy, done, cfg_err} == 6'b0, "R9",
            "outputs after reset", int'({ser_dat, ser_clk, ser_load, busy, done, cfg_err}), 0);
      for (int ch = 0; ch < 8; ch++)
         for (int v = 0; v < 256; v++)
            run_ok(ch, v, v % 2);
      for (int p = 2; p < 8; p += 5)
         for (int ch = 0; ch < 8; ch++)
            run_ok(ch, (8'hA5 ^ (ch * 37)) & 8'hff, p);
      run_ok(7, 8'hff, 3);
      run_ok(0, 8'h00, 3);
      for (int ch = 8; ch < 16; ch++)
         run_bad(ch, ch * 11);
      run_ok(5, 8'h3c, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule